// File: doc/BRIEF.md
# Serial Bus Access Mode Tracker

This block sits on the card side of a three-wire serial memory-card bus (serial clock, data, bus-state). It follows each transfer through its phases and decides whether the bus runs in the fallback two-state access mode or the full four-state access mode. The serial clock, data and bus-state lines are brought into the system clock domain through a synchronizer. Data and bus-state are sampled on each rising edge of the serial clock. A change of the sampled bus-state line marks a phase boundary, and the bit sampled at that edge already belongs to the new phase.

A transfer opens with a command phase (bus-state high) that carries an 8-bit command byte. A data phase (bus-state low) follows, then a handshake phase (bus-state high), and the bus-state falling edge closes the transfer. The tracker checks the command byte for integrity, for a known code and for the card's ability to execute it. On write commands it checks the length of the data phase and a CRC-16. It also checks that the card raised its ready indication before the handshake phase ended. Each failure sets its own sticky flag and drops the bus back to two-state mode. A clean command phase moves it to four-state mode.

Top module: `sbm_access_tracker`

## Requirements
- R1: After reset, `mode_four_o` is 0 (two-state mode), `phase_o` is 0 (idle), `err_o` is all zero and `cmd_code_o` is 0.
- R2: Bits are sampled on rising serial clock edges, most significant bit first. When a command is accepted, its high nibble appears on `cmd_code_o`. `cmd_write_o` is 1 for codes 11 to 14 and 0 for codes 2 to 5.
- R3: Phase encoding is 0 idle, 1 command, 2 data, 3 handshake. A rising bus-state edge in idle starts the command phase. A clean command phase sets `mode_four_o` to 1 and enters the data phase. A rising bus-state edge then enters the handshake phase, and a falling edge there returns to idle with the mode kept.
- R4: A command phase with fewer than 8 sampled edges sets `err_o[3]` (short command).
- R5: A command byte whose low nibble is not the bitwise complement of its high nibble sets `err_o[0]`.
- R6: A well-formed command whose code is not in {2,3,4,5,11,12,13,14} sets `err_o[1]`.
- R7: A defined command that arrives while `card_busy_i` is high at the end of the command phase sets `err_o[2]`.
- R8: On a write, a full-length data phase whose CRC-16 check fails sets `err_o[4]`. The CRC uses polynomial 0x1021 with initial value 0 and is sent MSB first after the data.
- R9: On a write, a data phase with fewer than DATA_BYTES*8+16 bits sets `err_o[5]` (short data), and the CRC is not judged.
- R10: A falling bus-state edge that ends the handshake phase before `card_rdy_i` was seen high in that phase sets `err_o[6]`.
- R11: Any newly detected error forces `mode_four_o` to 0 and `phase_o` to idle. A later clean command phase enters four-state mode again.
- R12: Error flags stay set until `err_clr_i` is high. If a new error is detected in the same cycle as a clear, the new flag is set and the older flags are cleared.
- R13: On a read command (codes 2 to 5), neither the length nor the content of the data phase is checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk_i | input | 1 | Serial bus clock, asynchronous |
| ser_dat_i | input | 1 | Serial data line, asynchronous |
| ser_bs_i | input | 1 | Bus-state line, asynchronous |
| card_busy_i | input | 1 | Card cannot execute commands now |
| card_rdy_i | input | 1 | Card ready indication for the handshake |
| err_clr_i | input | 1 | Clears all error flags |
| mode_four_o | output | 1 | 1 = four-state mode, 0 = two-state mode |
| phase_o | output | 2 | Current bus-state phase |
| cmd_code_o | output | 4 | Code of the last accepted command |
| cmd_write_o | output | 1 | Last accepted command is a write |
| err_o | output | 7 | Sticky per-cause error flags |

## Verification
The clear input and the detection of a new error can land in the same system clock cycle. In that cycle the new flag must win and the older flags must go. To provoke this, the bench first leaves an undefined-code flag set. It then sends a short command phase and raises the clear for exactly the one cycle in which the synchronized serial clock edge that ends the phase is acted on. That cycle is the third system clock edge after the serial clock rises. The outputs pass only if the short-command flag alone remains.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_DATA = 2'd2,
        PH_HS   = 2'd3
    } sbm_phase_e;

    localparam int ERR_CHK        = 0;
    localparam int ERR_UNDEF      = 1;
    localparam int ERR_BUSY       = 2;
    localparam int ERR_SHORT_CMD  = 3;
    localparam int ERR_CRC        = 4;
    localparam int ERR_SHORT_DATA = 5;
    localparam int ERR_SHORT_HS   = 6;
    localparam int ERR_N          = 7;

    localparam int          CRC_W    = 16;
    localparam logic [15:0] CRC_POLY = 16'h1021;
endpackage

// File: rtl/sbm_sync_edge.sv
module sbm_sync_edge #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic             strobe_o
);
    // stage STAGES is one extra flop used only for edge detection on bit 0
    logic [WIDTH-1:0] stg_q [STAGES+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= async_i;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= '0;
            else        stg_q[g] <= stg_q[g-1];
        end
    end

    assign level_o  = stg_q[STAGES-1];
    assign strobe_o = stg_q[STAGES-1][0] & ~stg_q[STAGES][0];
endmodule

// File: rtl/sbm_cmd_check.sv
module sbm_cmd_check #(
    parameter int          CMD_W      = 8,
    parameter logic [15:0] VALID_MASK = 16'h783C,
    parameter logic [15:0] WRITE_MASK = 16'h7800
) (
    input  logic [CMD_W-1:0]   cmd_i,
    input  logic               busy_i,
    output logic [CMD_W/2-1:0] code_o,
    output logic               chk_ok_o,
    output logic               defined_o,
    output logic               write_o,
    output logic               exec_ok_o
);
    localparam int NIB = CMD_W / 2;

    logic [NIB-1:0] hi_nib;
    logic [NIB-1:0] lo_nib;

    assign hi_nib    = cmd_i[CMD_W-1:NIB];
    assign lo_nib    = cmd_i[NIB-1:0];
    assign code_o    = hi_nib;
    assign chk_ok_o  = (lo_nib == ~hi_nib);
    assign defined_o = VALID_MASK[hi_nib];
    assign write_o   = WRITE_MASK[hi_nib];
    assign exec_ok_o = ~busy_i;
endmodule

// File: rtl/sbm_crc_step.sv
module sbm_crc_step #(
    parameter int           W    = 16,
    parameter logic [W-1:0] POLY = 16'h1021
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic fb;
    assign fb    = crc_i[W-1] ^ bit_i;
    assign crc_o = {crc_i[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
endmodule

// File: rtl/sbm_access_tracker.sv
module sbm_access_tracker
    import sbm_pkg::*;
#(
    parameter int          DATA_BYTES    = 4,
    parameter int          SYNC_STAGES   = 2,
    parameter int          MIN_CMD_EDGES = 8,
    parameter logic [15:0] VALID_MASK    = 16'h783C,
    parameter logic [15:0] WRITE_MASK    = 16'h7800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk_i,
    input  logic             ser_dat_i,
    input  logic             ser_bs_i,
    input  logic             card_busy_i,
    input  logic             card_rdy_i,
    input  logic             err_clr_i,
    output logic             mode_four_o,
    output logic [1:0]       phase_o,
    output logic [3:0]       cmd_code_o,
    output logic             cmd_write_o,
    output logic [ERR_N-1:0] err_o
);
    localparam int CMD_W      = 8;
    localparam int CODE_W     = CMD_W / 2;
    localparam int FRAME_BITS = DATA_BYTES * 8 + CRC_W;
    localparam int CNT_LIM    = (FRAME_BITS > MIN_CMD_EDGES) ? FRAME_BITS : MIN_CMD_EDGES;
    localparam int CNT_W      = $clog2(CNT_LIM + 1) + 1;
    localparam logic [CNT_W-1:0] MIN_CNT   = CNT_W'(MIN_CMD_EDGES);
    localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;

    typedef struct packed {
        sbm_phase_e       phase;
        logic             four;
        logic [CMD_W-1:0] shreg;
        logic [CNT_W-1:0] cnt;
        logic [CRC_W-1:0] crc;
        logic             is_write;
        logic [CODE_W-1:0] code;
        logic             rdy_seen;
        logic             bs_prev;
        logic [ERR_N-1:0] err;
    } trk_state_t;

    trk_state_t cur_q, nxt_d;

    // synchronized serial lines: bit0 clock, bit1 data, bit2 bus-state
    logic [2:0] sync_lvl;
    logic       sclk_rise;
    logic       dat_lvl;
    logic       bs_lvl;

    sbm_sync_edge #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_i  ({ser_bs_i, ser_dat_i, ser_clk_i}),
        .level_o  (sync_lvl),
        .strobe_o (sclk_rise)
    );

    assign dat_lvl = sync_lvl[1];
    assign bs_lvl  = sync_lvl[2];

    logic [CODE_W-1:0] dec_code;
    logic              dec_chk_ok;
    logic              dec_defined;
    logic              dec_write;
    logic              dec_exec_ok;

    sbm_cmd_check #(
        .CMD_W      (CMD_W),
        .VALID_MASK (VALID_MASK),
        .WRITE_MASK (WRITE_MASK)
    ) u_cmd (
        .cmd_i     (cur_q.shreg),
        .busy_i    (card_busy_i),
        .code_o    (dec_code),
        .chk_ok_o  (dec_chk_ok),
        .defined_o (dec_defined),
        .write_o   (dec_write),
        .exec_ok_o (dec_exec_ok)
    );

    logic [CRC_W-1:0] crc_seed;
    logic [CRC_W-1:0] crc_next;

    // the first data bit starts a fresh CRC, later bits extend the running one
    assign crc_seed = (cur_q.phase == PH_CMD) ? '0 : cur_q.crc;

    sbm_crc_step #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .crc_i (crc_seed),
        .bit_i (dat_lvl),
        .crc_o (crc_next)
    );

    logic [ERR_N-1:0] new_err;
    logic [CNT_W-1:0] cnt_inc;
    logic             bs_chg;

    always_comb begin
        nxt_d   = cur_q;
        new_err = '0;
        cnt_inc = (cur_q.cnt == CNT_MAX) ? cur_q.cnt : cur_q.cnt + 1'b1;
        bs_chg  = (bs_lvl != cur_q.bs_prev);

        if (err_clr_i) nxt_d.err = '0;

        if (sclk_rise) begin
            nxt_d.bs_prev = bs_lvl;
            unique case (cur_q.phase)
                PH_IDLE: begin
                    if (bs_chg && bs_lvl) begin
                        nxt_d.phase = PH_CMD;
                        nxt_d.cnt   = CNT_W'(1);
                        nxt_d.shreg = {{(CMD_W-1){1'b0}}, dat_lvl};
                    end
                end
                PH_CMD: begin
                    if (!bs_chg) begin
                        nxt_d.shreg = {cur_q.shreg[CMD_W-2:0], dat_lvl};
                        nxt_d.cnt   = cnt_inc;
                    end else begin
                        if (cur_q.cnt < MIN_CNT)  new_err[ERR_SHORT_CMD] = 1'b1;
                        else if (!dec_chk_ok)     new_err[ERR_CHK]       = 1'b1;
                        else if (!dec_defined)    new_err[ERR_UNDEF]     = 1'b1;
                        else if (!dec_exec_ok)    new_err[ERR_BUSY]      = 1'b1;
                        else begin
                            nxt_d.four     = 1'b1;
                            nxt_d.phase    = PH_DATA;
                            nxt_d.code     = dec_code;
                            nxt_d.is_write = dec_write;
                            nxt_d.cnt      = CNT_W'(1);
                            nxt_d.crc      = crc_next;
                        end
                    end
                end
                PH_DATA: begin
                    if (!bs_chg) begin
                        if (cur_q.cnt < FRAME_CNT) nxt_d.crc = crc_next;
                        nxt_d.cnt = cnt_inc;
                    end else begin
                        if (cur_q.is_write && (cur_q.cnt < FRAME_CNT))
                            new_err[ERR_SHORT_DATA] = 1'b1;
                        else if (cur_q.is_write && (cur_q.crc != '0))
                            new_err[ERR_CRC] = 1'b1;
                        else begin
                            nxt_d.phase    = PH_HS;
                            nxt_d.rdy_seen = 1'b0;
                        end
                    end
                end
                PH_HS: begin
                    if (bs_chg) begin
                        if (!(cur_q.rdy_seen || card_rdy_i))
                            new_err[ERR_SHORT_HS] = 1'b1;
                        else
                            nxt_d.phase = PH_IDLE;
                    end
                end
                default: nxt_d.phase = PH_IDLE;
            endcase
        end

        if ((cur_q.phase == PH_HS) && card_rdy_i) nxt_d.rdy_seen = 1'b1;

        if (new_err != '0) begin
            nxt_d.err   = nxt_d.err | new_err;
            nxt_d.four  = 1'b0;
            nxt_d.phase = PH_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q          <= '0;
            cur_q.phase    <= PH_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mode_four_o = cur_q.four;
    assign phase_o     = cur_q.phase;
    assign cmd_code_o  = cur_q.code;
    assign cmd_write_o = cur_q.is_write;
    assign err_o       = cur_q.err;
endmodule

// File: rtl/sbm_access_tracker_chk.sv
module sbm_access_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       err_clr_i,
    input logic       mode_four_o,
    input logic [1:0] phase_o,
    input logic [6:0] err_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!mode_four_o && phase_o == 2'd0 && err_o == 7'd0));

    // R12
    sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr_i |=> ((err_o & $past(err_o)) == $past(err_o)));

    // R11
    err_drops_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_o & ~$past(err_o)) != 7'd0) |-> (!mode_four_o && phase_o == 2'd0));

    // R3
    four_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_four_o) |-> (phase_o == 2'd2 && $past(phase_o) == 2'd1));

    // R3
    hs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd3 && $past(phase_o) != 2'd3) |-> ($past(phase_o) == 2'd2 && mode_four_o));

    // R4
    one_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err_o & ~$past(err_o)));
endmodule

bind sbm_access_tracker sbm_access_tracker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_clr_i   (err_clr_i),
    .mode_four_o (mode_four_o),
    .phase_o     (phase_o),
    .err_o       (err_o)
);

// File: tb/sbm_access_tracker_tb.sv
module sbm_access_tracker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int NB         = 4;
    localparam int FRAME      = NB * 8 + 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdat = 1'b0, sbs = 1'b0;
    logic busy = 1'b0, rdy = 1'b0, clr = 1'b0;
    logic       mode_four;
    logic [1:0] phase;
    logic [3:0] code;
    logic       wr;
    logic [6:0] err;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbm_access_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_bs_i(sbs),
        .card_busy_i(busy), .card_rdy_i(rdy), .err_clr_i(clr),
        .mode_four_o(mode_four), .phase_o(phase), .cmd_code_o(code),
        .cmd_write_o(wr), .err_o(err)
    );

    typedef struct {
        logic       four;
        logic [1:0] ph;
        logic [6:0] er;
        logic [3:0] cd;
        logic       wr;
        bit         chk_cd;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    event exp_ev;
    int   checks = 0;
    int   errors = 0;

    task automatic cmp(string tag, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(exp_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                cmp(e.tag, "mode", int'(mode_four), int'(e.four));
                cmp(e.tag, "phase", int'(phase), int'(e.ph));
                cmp(e.tag, "err", int'(err), int'(e.er));
                if (e.chk_cd) begin
                    cmp(e.tag, "code", int'(code), int'(e.cd));
                    cmp(e.tag, "write", int'(wr), int'(e.wr));
                end
            end
        end
    end

    task automatic expect_st(logic f, logic [1:0] p, logic [6:0] e, logic [3:0] c,
                             logic w, bit cc, string tag);
        exp_t x;
        x.four = f; x.ph = p; x.er = e; x.cd = c; x.wr = w; x.chk_cd = cc; x.tag = tag;
        exp_q.push_back(x);
        -> exp_ev;
    endtask

    // one serial bit: lines change with the serial clock low, then it rises
    task automatic ser_bit(logic b, logic d, bit clr_hit);
        @(negedge clk);
        sclk = 1'b0; sbs = b; sdat = d;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        if (clr_hit) begin
            repeat (2) @(posedge clk);
            @(negedge clk) clr = 1'b1;
            @(negedge clk) clr = 1'b0;
            repeat (HALF - 3) @(negedge clk);
        end else begin
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic send_bits(logic b, logic [63:0] v, int n);
        for (int i = n - 1; i >= 0; i--) ser_bit(b, v[i], 1'b0);
    endtask

    task automatic pulse_clr();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [15:0] crc16(logic [NB*8-1:0] d);
        logic [15:0] c = 16'h0000;
        for (int i = NB*8 - 1; i >= 0; i--) begin
            logic fb = c[15] ^ d[i];
            c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return c;
    endfunction

    function automatic logic [63:0] mk_frame(logic [NB*8-1:0] d, bit corrupt);
        logic [63:0] f = 64'(d) << 16 | 64'(crc16(d));
        if (corrupt) f[5] = ~f[5];
        return f;
    endfunction

    // complete clean write transfer with ready given
    task automatic good_write(logic [NB*8-1:0] d, string tag);
        logic [63:0] f = mk_frame(d, 1'b0);
        send_bits(1'b1, 64'hB4, 8);
        send_bits(1'b0, f >> (FRAME - 1), 1);
        expect_st(1'b1, 2'd2, 7'h00, 4'hB, 1'b1, 1'b1, {tag, " R2 R3 command accepted"});
        send_bits(1'b0, f, FRAME - 1);
        rdy = 1'b1;
        send_bits(1'b1, 64'h0, 1);
        expect_st(1'b1, 2'd3, 7'h00, 4'hB, 1'b1, 1'b1, {tag, " R3 R8 handshake phase"});
        send_bits(1'b1, 64'h0, 1);
        send_bits(1'b0, 64'h0, 1);
        expect_st(1'b1, 2'd0, 7'h00, 4'hB, 1'b1, 1'b1, {tag, " R3 R10 transfer done"});
        rdy = 1'b0;
        send_bits(1'b0, 64'h0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        expect_st(1'b0, 2'd0, 7'h00, 4'h0, 1'b0, 1'b1, "R1 reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        expect_st(1'b0, 2'd0, 7'h00, 4'h0, 1'b0, 1'b1, "R1 after release");
        send_bits(1'b0, 64'h0, 2);

        good_write(32'hA5C3_0F81, "first");

        // R13 read: short and arbitrary data phase is accepted
        send_bits(1'b1, 64'h3C, 8);
        send_bits(1'b0, 64'h15, 5);
        rdy = 1'b1;
        send_bits(1'b1, 64'h0, 2);
        send_bits(1'b0, 64'h0, 1);
        expect_st(1'b1, 2'd0, 7'h00, 4'h3, 1'b0, 1'b1, "R13 R2 read unchecked data");
        rdy = 1'b0;
        send_bits(1'b0, 64'h0, 1);

        // R4 short command
        send_bits(1'b1, 64'h16, 5);
        send_bits(1'b0, 64'h0, 2);
        expect_st(1'b0, 2'd0, 7'h08, 4'h0, 1'b0, 1'b0, "R4 R11 short command");
        pulse_clr();
        expect_st(1'b0, 2'd0, 7'h00, 4'h0, 1'b0, 1'b0, "R12 clear alone");

        // R5 nibble check failure
        send_bits(1'b1, 64'hB5, 8);
        send_bits(1'b0, 64'h0, 2);
        expect_st(1'b0, 2'd0, 7'h01, 4'h0, 1'b0, 1'b0, "R5 check nibble");
        pulse_clr();

        // R6 undefined code, left set for the collision case
        send_bits(1'b1, 64'h78, 8);
        send_bits(1'b0, 64'h0, 2);
        expect_st(1'b0, 2'd0, 7'h02, 4'h0, 1'b0, 1'b0, "R6 undefined code");

        // R12 clear in the same cycle as a new short-command detection
        send_bits(1'b1, 64'h5, 3);
        ser_bit(1'b0, 1'b0, 1'b1);
        expect_st(1'b0, 2'd0, 7'h08, 4'h0, 1'b0, 1'b0, "R12 clear vs new error");
        send_bits(1'b0, 64'h0, 1);
        expect_st(1'b0, 2'd0, 7'h08, 4'h0, 1'b0, 1'b0, "R12 flag stays sticky");
        pulse_clr();

        // R7 busy card
        busy = 1'b1;
        send_bits(1'b1, 64'hB4, 8);
        send_bits(1'b0, 64'h0, 2);
        expect_st(1'b0, 2'd0, 7'h04, 4'h0, 1'b0, 1'b0, "R7 busy command");
        busy = 1'b0;
        pulse_clr();

        // R8 CRC mismatch on full-length write
        send_bits(1'b1, 64'hB4, 8);
        send_bits(1'b0, mk_frame(32'h1234_5678, 1'b1), FRAME);
        send_bits(1'b1, 64'h0, 1);
        expect_st(1'b0, 2'd0, 7'h10, 4'h0, 1'b0, 1'b0, "R8 R11 crc mismatch");
        send_bits(1'b0, 64'h0, 2);
        pulse_clr();

        // R9 short data phase on a write
        send_bits(1'b1, 64'hB4, 8);
        send_bits(1'b0, mk_frame(32'h1234_5678, 1'b0) >> 3, FRAME - 3);
        send_bits(1'b1, 64'h0, 1);
        expect_st(1'b0, 2'd0, 7'h20, 4'h0, 1'b0, 1'b0, "R9 short data");
        send_bits(1'b0, 64'h0, 2);
        pulse_clr();

        // R11 re-entry to four-state mode after errors
        good_write(32'h0000_0001, "R11 re-entry");

        // R10 handshake ended without ready
        begin
            logic [63:0] f = mk_frame(32'hFFFF_0000, 1'b0);
            send_bits(1'b1, 64'hB4, 8);
            send_bits(1'b0, f, FRAME);
            send_bits(1'b1, 64'h0, 2);
            expect_st(1'b1, 2'd3, 7'h00, 4'hB, 1'b1, 1'b1, "R10 waiting for ready");
            send_bits(1'b0, 64'h0, 1);
            expect_st(1'b0, 2'd0, 7'h40, 4'hB, 1'b1, 1'b1, "R10 short handshake");
        end

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule